// File: doc/BRIEF.md
# Mode-Dependent LCD Clock Divider

This block turns a 32768 Hz reference clock into the slow clocks a segment LCD driver needs: the frame (drive) clock, a blink-rate candidate and three low-frequency timing waves at 4 Hz, 2 Hz and 1 Hz. Every output is a 50% duty square wave taken from one bit of a single 15-bit free-running counter. The frame clock and the blink candidate run twice as fast in static drive as in half-duty drive. A change of the mode input only moves these two outputs to a neighbouring counter bit. The counter itself keeps running.

Alongside the divider sits a small event counter. It samples a count input on the reference clock, detects rising transitions and raises a sticky flag on the sixteenth one. The flag is controlled by a three-state machine:
- `EC_IDLE`: no edge seen yet.
- `EC_COUNT`: between one and fifteen edges seen.
- `EC_DONE`: the flag is high.

The transitions are:
- first-edge: `EC_IDLE` to `EC_COUNT`.
- next-edge: `EC_COUNT` to `EC_COUNT`, while fewer than fifteen edges have been seen.
- final-edge: `EC_COUNT` to `EC_DONE`, on the sixteenth edge.
- hold: `EC_DONE` to `EC_DONE`, until reset.

Top module: `lcd_clock_divider`

## Requirements
- R1: While `rst_n` is low, the counter and the edge machine are cleared, and all six outputs are low.
- R2: After reset is released, let n be the number of rising `clk_32k` edges, taken modulo 32768. Then `tick_4hz` equals bit 12 of n (divide by 8192), `tick_2hz` equals bit 13 (divide by 16384) and `tick_1hz` equals bit 14 (divide by 32768).
- R3: `lcd_clk` equals bit 7 of n when `half_duty` is 1 (divide by 256). It equals bit 6 of n when `half_duty` is 0 (divide by 128, static drive).
- R4: `blink_clk` equals bit 6 of n when `half_duty` is 1 (divide by 128). It equals bit 5 of n when `half_duty` is 0 (divide by 64).
- R5: A change of `half_duty` takes effect combinationally. It neither resets nor disturbs the counter, so the R2 to R4 relations hold across any number of mode switches.
- R6: A rising edge of `cnt_in` is a clock edge at which `cnt_in` is sampled high after being sampled low at the previous edge, or low during reset. `cnt_flag` goes high right after the clock edge that detects the sixteenth such edge. It stays low after fifteen.
- R7: Once high, `cnt_flag` stays high until reset. Holding `cnt_in` high counts as a single edge, and further edges have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_32k | input | 1 | 32768 Hz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_duty | input | 1 | Drive mode: 1 half-duty, 0 static |
| cnt_in | input | 1 | Count input, sampled on `clk_32k` |
| lcd_clk | output | 1 | LCD frame clock square wave |
| blink_clk | output | 1 | Blink-rate candidate square wave |
| tick_4hz | output | 1 | 4 Hz square wave |
| tick_2hz | output | 1 | 2 Hz square wave |
| tick_1hz | output | 1 | 1 Hz square wave |
| cnt_flag | output | 1 | Sticky flag set on the sixteenth count edge |

## Verification
A corrupted counter shows up on `blink_clk` or `lcd_clk` within 32 to 128 reference cycles. It shows up as a phase error that persists and that no later mode switch can hide. A wrong counter bit that only the slow waves use needs up to 32768 cycles, which is why the sweep covers more than one full counter period. An error in the edge machine shows up as `cnt_flag` rising one edge early or late, or falling again. The bench therefore compares the flag every cycle against its own edge tally, including the cycles around the fifteenth and sixteenth edges.

// File: rtl/lcdclk_pkg.sv
package lcdclk_pkg;
    typedef enum logic [1:0] {
        EC_IDLE  = 2'd0,
        EC_COUNT = 2'd1,
        EC_DONE  = 2'd2
    } edge_state_t;
endpackage

// File: rtl/lcdclk_prescaler.sv
module lcdclk_prescaler #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + ONE;
    end

    // R5
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) + ONE));
endmodule

// File: rtl/lcdclk_tap_mux.sv
module lcdclk_tap_mux #(
    parameter int CNT_W          = 15,
    parameter int LCD_TAP_HALF   = 7,
    parameter int BLINK_TAP_HALF = 6,
    parameter int SLOW_N         = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count,
    input  logic             half_duty,
    output logic             lcd_clk,
    output logic             blink_clk,
    output logic [SLOW_N-1:0] slow_clk
);
    localparam int LCD_TAP_STAT   = LCD_TAP_HALF - 1;
    localparam int BLINK_TAP_STAT = BLINK_TAP_HALF - 1;
    localparam int SLOW_BASE      = CNT_W - SLOW_N;

    always_comb begin
        lcd_clk   = half_duty ? count[LCD_TAP_HALF]   : count[LCD_TAP_STAT];
        blink_clk = half_duty ? count[BLINK_TAP_HALF] : count[BLINK_TAP_STAT];
    end

    for (genvar j = 0; j < SLOW_N; j++) begin : g_slow
        assign slow_clk[j] = count[SLOW_BASE + j];
    end

    // R3
    lcd_half_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (half_duty && $past(half_duty) && (lcd_clk != $past(lcd_clk)))
        |-> (count[LCD_TAP_HALF-1:0] == '0));

    // R4
    blink_stat_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!half_duty && !$past(half_duty) && (blink_clk != $past(blink_clk)))
        |-> (count[BLINK_TAP_STAT-1:0] == '0));

    // R2
    slow_top_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_clk[SLOW_N-1]) |-> (count[CNT_W-2:0] == '0));
endmodule

// File: rtl/lcdclk_edge_fsm.sv
module lcdclk_edge_fsm
    import lcdclk_pkg::*;
#(
    parameter int TARGET = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_in,
    output logic flag
);
    localparam int EW = $clog2(TARGET);
    localparam logic [EW-1:0] LAST = EW'(TARGET - 1);
    localparam logic [EW-1:0] ONE  = EW'(1);

    edge_state_t state, state_nx;
    logic [EW-1:0] seen, seen_nx;
    logic          cin_q;
    logic          rise;

    assign rise = cnt_in & ~cin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= EC_IDLE;
            seen  <= '0;
            cin_q <= 1'b0;
        end else begin
            state <= state_nx;
            seen  <= seen_nx;
            cin_q <= cnt_in;
        end
    end

    always_comb begin
        state_nx = state;
        seen_nx  = seen;
        unique case (state)
            EC_IDLE: begin
                if (rise) begin
                    state_nx = EC_COUNT;
                    seen_nx  = ONE;
                end
            end
            EC_COUNT: begin
                if (rise) begin
                    if (seen == LAST) state_nx = EC_DONE;
                    else              seen_nx  = seen + ONE;
                end
            end
            EC_DONE: begin
                state_nx = EC_DONE;
            end
            default: begin
                state_nx = EC_IDLE;
                seen_nx  = '0;
            end
        endcase
    end

    always_comb begin
        flag = (state == EC_DONE);
    end

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag |=> flag);

    // R6
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(rise) && ($past(seen) == LAST)));
endmodule

// File: rtl/lcd_clock_divider.sv
module lcd_clock_divider #(
    parameter int CNT_W          = 15,
    parameter int LCD_TAP_HALF   = 7,
    parameter int BLINK_TAP_HALF = 6,
    parameter int EDGE_TARGET    = 16
) (
    input  logic clk_32k,
    input  logic rst_n,
    input  logic half_duty,
    input  logic cnt_in,
    output logic lcd_clk,
    output logic blink_clk,
    output logic tick_4hz,
    output logic tick_2hz,
    output logic tick_1hz,
    output logic cnt_flag
);
    localparam int SLOW_N = 3;

    logic [CNT_W-1:0]  count;
    logic [SLOW_N-1:0] slow_clk;

    lcdclk_prescaler #(.CNT_W(CNT_W)) u_pre (
        .clk   (clk_32k),
        .rst_n (rst_n),
        .count (count)
    );

    lcdclk_tap_mux #(
        .CNT_W          (CNT_W),
        .LCD_TAP_HALF   (LCD_TAP_HALF),
        .BLINK_TAP_HALF (BLINK_TAP_HALF),
        .SLOW_N         (SLOW_N)
    ) u_tap (
        .clk       (clk_32k),
        .rst_n     (rst_n),
        .count     (count),
        .half_duty (half_duty),
        .lcd_clk   (lcd_clk),
        .blink_clk (blink_clk),
        .slow_clk  (slow_clk)
    );

    assign tick_4hz = slow_clk[0];
    assign tick_2hz = slow_clk[1];
    assign tick_1hz = slow_clk[2];

    lcdclk_edge_fsm #(.TARGET(EDGE_TARGET)) u_edge (
        .clk    (clk_32k),
        .rst_n  (rst_n),
        .cnt_in (cnt_in),
        .flag   (cnt_flag)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk_32k)
        !rst_n |-> !(lcd_clk | blink_clk | tick_4hz | tick_2hz | tick_1hz | cnt_flag));
endmodule

// File: tb/lcd_clock_divider_tb.sv
module lcd_clock_divider_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic half_duty = 1'b1;
    logic cnt_in = 1'b0;
    logic lcd_clk, blink_clk, tick_4hz, tick_2hz, tick_1hz, cnt_flag;

    int n_checks = 0;
    int n_fail = 0;
    int unsigned n_edges = 0;
    int edges = 0;
    logic prev_in = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_clock_divider dut_i (
        .clk_32k(clk), .rst_n(rst_n), .half_duty(half_duty), .cnt_in(cnt_in),
        .lcd_clk(lcd_clk), .blink_clk(blink_clk), .tick_4hz(tick_4hz),
        .tick_2hz(tick_2hz), .tick_1hz(tick_1hz), .cnt_flag(cnt_flag)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at n=%0d", req, act, exp, n_edges);
        end
    endtask

    function automatic logic nbit(input int k);
        int unsigned m = n_edges % 32768;
        return logic'((m >> k) & 1);
    endfunction

    task automatic check_all();
        chk("R2 tick_4hz", tick_4hz, nbit(12));
        chk("R2 tick_2hz", tick_2hz, nbit(13));
        chk("R2 tick_1hz", tick_1hz, nbit(14));
        chk("R3 lcd_clk",  lcd_clk,  half_duty ? nbit(7) : nbit(6));
        chk("R4 blink_clk", blink_clk, half_duty ? nbit(6) : nbit(5));
        chk("R6 cnt_flag", cnt_flag, logic'(edges >= 16));
    endtask

    // advance one clock edge, update model, then apply new inputs
    task automatic tick(input logic m, input logic c);
        @(posedge clk);
        if (cnt_in && !prev_in) edges++;
        prev_in = cnt_in;
        n_edges++;
        #1;
        half_duty = m;
        cnt_in = c;
        @(negedge clk);
        check_all();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cnt_in = 1'b0;
        #1;
        // R1
        chk("R1 lcd_clk", lcd_clk, 1'b0);
        chk("R1 blink_clk", blink_clk, 1'b0);
        chk("R1 tick_1hz", tick_1hz, 1'b0);
        chk("R1 tick_2hz", tick_2hz, 1'b0);
        chk("R1 tick_4hz", tick_4hz, 1'b0);
        chk("R1 cnt_flag", cnt_flag, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        n_edges = 0;
        edges = 0;
        prev_in = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 250000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R5: rapid mode switching early on
        for (int i = 0; i < 600; i++) tick(logic'((i / 7) % 2), 1'b0);
        // R6: exact boundary at fifteen and sixteen edges
        for (int e = 0; e < 15; e++) begin
            tick(half_duty, 1'b1);
            tick(half_duty, 1'b0);
            tick(half_duty, 1'b0);
        end
        chk("R6 flag low after 15 edges", cnt_flag, 1'b0);
        tick(half_duty, 1'b1);
        tick(half_duty, 1'b0);
        chk("R6 flag high after 16th edge", cnt_flag, 1'b1);
        // R2 R3 R4 R5 R7: long sweep over more than two counter periods
        for (int i = 0; i < 70000; i++)
            tick(logic'((i / 3001) % 2), logic'((i % (3 + (i / 50) % 5)) == 0));
        chk("R7 flag still high", cnt_flag, 1'b1);
        // R1 mid-run reset, then R7 held-high input counts once
        do_reset();
        for (int i = 0; i < 200; i++) tick(1'b0, 1'b1);
        chk("R7 held input is one edge", cnt_flag, 1'b0);
        for (int e = 0; e < 14; e++) begin
            tick(1'b1, 1'b0);
            tick(1'b1, 1'b1);
        end
        tick(1'b1, 1'b0);
        chk("R6 flag low at 15 edges", cnt_flag, 1'b0);
        tick(1'b1, 1'b1);
        tick(1'b1, 1'b1);
        chk("R6 flag set at 16 edges", cnt_flag, 1'b1);
        for (int i = 0; i < 300; i++) tick(logic'(i % 2), logic'(i % 3 == 0));
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule